// File: doc/BRIEF.md
# Multi-CPU Masked Interrupt Router

This block collects up to 64 device interrupt request lines into one shared raw request vector and hands each of several CPUs its own filtered view of it. Every CPU owns a mask register. Its pending register is the raw vector ANDed with that mask. Each CPU also has a saturating count of inter-processor interrupts (IPIs) and a flag for a real-time-clock tick. A CPU's interrupt output is high whenever any of these three sources needs attention.

Software reaches the block through a simple register bus. Each access carries the number of the CPU that makes it. The window covers 0x1000 bytes, and every register is 64 bits wide at a 64-byte-aligned offset. A control register reads back the caller's CPU number. Writes to it raise IPIs, retire IPIs and clear RTC flags, with one bit per CPU for each action. Device-side logic posts and retires single request lines by their number through two separate strobe ports.

Top module: `irq_router_top`

## Requirements
- R1: While reset is held and right after it, all masks, the raw vector, the IPI counts and the RTC flags are zero, every `irq_out` bit is low, and every read returns zero.
- R2: A `set_vld` pulse makes raw bit `set_num` 1 and a `clr_vld` pulse makes raw bit `clr_num` 0, both from the next clock edge. If both name the same line in one cycle, the set wins. The raw vector reads back at offset 0x200.
- R3: The mask of CPU n is at offset 0x040*n (n below NCPU). A write stores `bus_wdata` and a read returns the stored value.
- R4: A read at offset 0x100 + 0x040*n returns the raw vector ANDed with the mask of CPU n.
- R5: The pending registers and the raw vector are read-only. A write to them changes no register, and a mask changes only on a write to its own offset.
- R6: A read of any offset that is not listed, including one that is not 64-byte aligned, returns zero, and a write there has no effect. `bus_rdata` is zero while `bus_rd` is low.
- R7: A read at the control offset 0x240 returns `bus_cpu` in bits [1:0], with all other bits zero.
- R8: An `rtc_tick` pulse sets the RTC flag of every CPU. Writing 1 to control bit 4+n clears the flag of CPU n. A tick in the same cycle as the clear leaves the flag set.
- R9: Writing 1 to control bit 12+n adds one to the IPI count of CPU n, which stops at 15. Writing 1 to bit 8+n subtracts one, which stops at 0. Both bits in one write leave the count unchanged.
- R10: `irq_out[n]` is high exactly when the pending register of CPU n is non-zero, its IPI count is non-zero, or its RTC flag is set. It follows the registered state in the cycle after the clock edge that updates that state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read data is combinational) |
| bus_addr | input | 12 | Byte offset in the register window |
| bus_wdata | input | 64 | Write data |
| bus_cpu | input | 2 | Number of the accessing CPU |
| bus_rdata | output | 64 | Read data, zero when no read |
| set_vld | input | 1 | Post a raw request line |
| set_num | input | 6 | Line to post |
| clr_vld | input | 1 | Retire a raw request line |
| clr_num | input | 6 | Line to retire |
| rtc_tick | input | 1 | Real-time-clock tick, one cycle |
| irq_out | output | 4 | Interrupt output, one per CPU |

## Verification
The assertions expect `rtc_tick`, `set_vld` and `clr_vld` to be clean single-cycle levels that are sampled at each edge. They also expect `set_num` and `clr_num` to stay inside the line range, because the raw-vector checks index with them. The interrupt-cause property expects a rising `irq_out` to come only from a tick, an IPI raise, a posted line or a mask write. The stimulus drives every input just after the falling edge and keeps the line numbers six bits wide. It reaches the saturation limits of the IPI counts by direct write sequences and not by chance.

// File: rtl/irq_router_pkg.sv
package irq_router_pkg;
  localparam int unsigned ADDR_W = 12;
  localparam logic [ADDR_W-1:0] RAW_OFS  = 12'h200;
  localparam logic [ADDR_W-1:0] CTRL_OFS = 12'h240;
  localparam int unsigned RTC_ACK_LSB   = 4;
  localparam int unsigned IPI_ACK_LSB   = 8;
  localparam int unsigned IPI_RAISE_LSB = 12;

  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_MASK,
    SEL_PEND,
    SEL_RAW,
    SEL_CTRL
  } reg_sel_e;

  // Region decode: 64-byte slots, mask bank in page 0, pending bank in page 1
  function automatic reg_sel_e classify(input logic [ADDR_W-1:0] addr,
                                        input int unsigned ncpu);
    if (addr[5:0] != 6'd0) return SEL_NONE;
    if (addr[11:8] == 4'h0)
      return ({30'd0, addr[7:6]} < ncpu) ? SEL_MASK : SEL_NONE;
    if (addr[11:8] == 4'h1)
      return ({30'd0, addr[7:6]} < ncpu) ? SEL_PEND : SEL_NONE;
    if (addr == RAW_OFS)  return SEL_RAW;
    if (addr == CTRL_OFS) return SEL_CTRL;
    return SEL_NONE;
  endfunction
endpackage

// File: rtl/irq_raw_vec.sv
module irq_raw_vec #(
  parameter int NLINES = 64,
  localparam int LW = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_vld,
  input  logic [LW-1:0]     set_num,
  input  logic              clr_vld,
  input  logic [LW-1:0]     clr_num,
  output logic [NLINES-1:0] raw
);
  for (genvar i = 0; i < NLINES; i++) begin : g_line
    logic hit_set, hit_clr;
    assign hit_set = set_vld && (set_num == LW'(i));
    assign hit_clr = clr_vld && (clr_num == LW'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)       raw[i] <= 1'b0;
      else if (hit_set) raw[i] <= 1'b1;
      else if (hit_clr) raw[i] <= 1'b0;
    end
  end
endmodule

// File: rtl/irq_cpu_ctx.sv
module irq_cpu_ctx #(
  parameter int NLINES = 64,
  parameter int CW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mask_wr,
  input  logic [NLINES-1:0] mask_wdata,
  input  logic [NLINES-1:0] raw,
  input  logic              rtc_tick,
  input  logic              rtc_ack,
  input  logic              ipi_inc,
  input  logic              ipi_dec,
  output logic [NLINES-1:0] mask_q,
  output logic [NLINES-1:0] pend,
  output logic [CW-1:0]     ipi_cnt,
  output logic              rtc_flag,
  output logic              irq
);
  localparam logic [CW-1:0] CNT_MAX = '1;

  function automatic logic [CW-1:0] ipi_next(input logic [CW-1:0] cur,
                                             input logic up, input logic dn);
    if (up && !dn && cur != CNT_MAX) return cur + CW'(1);
    if (dn && !up && cur != '0)      return cur - CW'(1);
    return cur;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q   <= '0;
      ipi_cnt  <= '0;
      rtc_flag <= 1'b0;
    end else begin
      if (mask_wr) mask_q <= mask_wdata;
      ipi_cnt <= ipi_next(ipi_cnt, ipi_inc, ipi_dec);
      if (rtc_tick)     rtc_flag <= 1'b1;
      else if (rtc_ack) rtc_flag <= 1'b0;
    end
  end

  assign pend = raw & mask_q;
  assign irq  = (|pend) || (|ipi_cnt) || rtc_flag;
endmodule

// File: rtl/irq_router_top.sv
module irq_router_top
  import irq_router_pkg::*;
#(
  parameter int NCPU   = 4,
  parameter int NLINES = 64,
  parameter int DW     = 64,
  parameter int CW     = 4,
  parameter int IDW    = 2,
  localparam int LW    = $clog2(NLINES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DW-1:0]     bus_wdata,
  input  logic [IDW-1:0]    bus_cpu,
  output logic [DW-1:0]     bus_rdata,
  input  logic              set_vld,
  input  logic [LW-1:0]     set_num,
  input  logic              clr_vld,
  input  logic [LW-1:0]     clr_num,
  input  logic              rtc_tick,
  output logic [NCPU-1:0]   irq_out
);
  reg_sel_e   sel;
  logic [1:0] slot;
  logic       ctrl_wr;

  // Named internal events, also observed by the checker
  logic [NLINES-1:0]              raw_v;
  logic [NCPU-1:0][NLINES-1:0]    mask_v;
  logic [NCPU-1:0][NLINES-1:0]    pend_v;
  logic [NCPU-1:0][CW-1:0]        ipi_cnt_v;
  logic [NCPU-1:0]                rtc_v;
  logic [NCPU-1:0]                mask_wr_v;
  logic [NCPU-1:0]                ipi_inc_v;
  logic [NCPU-1:0]                ipi_dec_v;
  logic [NCPU-1:0]                rtc_ack_v;

  assign sel     = classify(bus_addr, NCPU);
  assign slot    = bus_addr[7:6];
  assign ctrl_wr = bus_wr && (sel == SEL_CTRL);

  irq_raw_vec #(.NLINES(NLINES)) u_raw (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_vld (set_vld),
    .set_num (set_num),
    .clr_vld (clr_vld),
    .clr_num (clr_num),
    .raw     (raw_v)
  );

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    assign mask_wr_v[c] = bus_wr && (sel == SEL_MASK) && (slot == 2'(c));
    assign rtc_ack_v[c] = ctrl_wr && bus_wdata[RTC_ACK_LSB + c];
    assign ipi_dec_v[c] = ctrl_wr && bus_wdata[IPI_ACK_LSB + c];
    assign ipi_inc_v[c] = ctrl_wr && bus_wdata[IPI_RAISE_LSB + c];

    irq_cpu_ctx #(.NLINES(NLINES), .CW(CW)) u_ctx (
      .clk        (clk),
      .rst_n      (rst_n),
      .mask_wr    (mask_wr_v[c]),
      .mask_wdata (bus_wdata[NLINES-1:0]),
      .raw        (raw_v),
      .rtc_tick   (rtc_tick),
      .rtc_ack    (rtc_ack_v[c]),
      .ipi_inc    (ipi_inc_v[c]),
      .ipi_dec    (ipi_dec_v[c]),
      .mask_q     (mask_v[c]),
      .pend       (pend_v[c]),
      .ipi_cnt    (ipi_cnt_v[c]),
      .rtc_flag   (rtc_v[c]),
      .irq        (irq_out[c])
    );
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (sel)
        SEL_MASK: for (int c = 0; c < NCPU; c++)
                    if (slot == 2'(c)) bus_rdata = DW'(mask_v[c]);
        SEL_PEND: for (int c = 0; c < NCPU; c++)
                    if (slot == 2'(c)) bus_rdata = DW'(pend_v[c]);
        SEL_RAW:  bus_rdata = DW'(raw_v);
        SEL_CTRL: bus_rdata = DW'(bus_cpu);
        default:  bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/irq_router_chk.sv
module irq_router_chk #(
  parameter int NCPU   = 4,
  parameter int NLINES = 64,
  parameter int CW     = 4,
  localparam int LW    = $clog2(NLINES)
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic                           rtc_tick,
  input logic                           set_vld,
  input logic [LW-1:0]                  set_num,
  input logic                           clr_vld,
  input logic [LW-1:0]                  clr_num,
  input logic [NLINES-1:0]              raw_v,
  input logic [NCPU-1:0][NLINES-1:0]    mask_v,
  input logic [NCPU-1:0]                mask_wr_v,
  input logic [NCPU-1:0]                ipi_inc_v,
  input logic [NCPU-1:0]                ipi_dec_v,
  input logic [NCPU-1:0][CW-1:0]        ipi_cnt_v,
  input logic [NCPU-1:0]                rtc_v,
  input logic [NCPU-1:0]                rtc_ack_v,
  input logic [NCPU-1:0]                irq_out
);
  AST_RTC_TICK_SETS_ALL: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_tick |=> (&rtc_v)); // R8
  AST_MASK_WR_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(mask_wr_v)); // R3
  AST_RAW_SET_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    set_vld |=> raw_v[$past(set_num)]); // R2
  AST_RAW_CLR_LANDS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_vld && !(set_vld && set_num == clr_num)) |=> !raw_v[$past(clr_num)]); // R2

  for (genvar c = 0; c < NCPU; c++) begin : g_cpu
    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      !mask_wr_v[c] |=> $stable(mask_v[c])); // R5
    AST_IPI_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_inc_v[c] && !ipi_dec_v[c] && ipi_cnt_v[c] != '1)
        |=> ipi_cnt_v[c] == $past(ipi_cnt_v[c]) + CW'(1)); // R9
    AST_IPI_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (ipi_dec_v[c] && !ipi_inc_v[c] && ipi_cnt_v[c] == '0)
        |=> ipi_cnt_v[c] == '0); // R9
    AST_RTC_ACK_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
      (rtc_ack_v[c] && !rtc_tick) |=> !rtc_v[c]); // R8
    AST_IRQ_ROSE_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_out[c]) |-> $past(rtc_tick || ipi_inc_v[c] || set_vld || mask_wr_v[c])); // R10
  end
endmodule

bind irq_router_top irq_router_chk #(.NCPU(NCPU), .NLINES(NLINES), .CW(CW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rtc_tick  (rtc_tick),
  .set_vld   (set_vld),
  .set_num   (set_num),
  .clr_vld   (clr_vld),
  .clr_num   (clr_num),
  .raw_v     (raw_v),
  .mask_v    (mask_v),
  .mask_wr_v (mask_wr_v),
  .ipi_inc_v (ipi_inc_v),
  .ipi_dec_v (ipi_dec_v),
  .ipi_cnt_v (ipi_cnt_v),
  .rtc_v     (rtc_v),
  .rtc_ack_v (rtc_ack_v),
  .irq_out   (irq_out)
);

// File: tb/irq_router_top_tb.sv
`timescale 1ns/1ps
module irq_router_top_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [63:0] bus_wdata = '0;
  logic [1:0]  bus_cpu = '0;
  logic [63:0] bus_rdata;
  logic        set_vld = 1'b0, clr_vld = 1'b0, rtc_tick = 1'b0;
  logic [5:0]  set_num = '0, clr_num = '0;
  logic [3:0]  irq_out;

  int n_cmp = 0, n_bad = 0;

  // Behavioural reference state
  logic [63:0] m_raw;
  logic [63:0] m_mask [4];
  int          m_ipi  [4];
  bit          m_rtc  [4];

  irq_router_top u_dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_cpu(bus_cpu),
    .bus_rdata(bus_rdata), .set_vld(set_vld), .set_num(set_num),
    .clr_vld(clr_vld), .clr_num(clr_num), .rtc_tick(rtc_tick),
    .irq_out(irq_out)
  );

  always #4 clk = ~clk;

  initial begin
    #(8 * 200000);
    n_bad++;
    $display("FAIL R10 watchdog: actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  function automatic void model_clear();
    m_raw = '0;
    for (int c = 0; c < 4; c++) begin m_mask[c] = '0; m_ipi[c] = 0; m_rtc[c] = 0; end
  endfunction

  function automatic logic [63:0] exp_rdata();
    int a = int'(bus_addr);
    if (!bus_rd || (a % 64) != 0) return '0;
    if (a < 256) return m_mask[a / 64];
    if (a < 512) return m_raw & m_mask[(a - 256) / 64];
    if (a == 512) return m_raw;
    if (a == 576) return {62'd0, bus_cpu};
    return '0;
  endfunction

  function automatic string tag_of();
    int a = int'(bus_addr);
    if ((a % 64) != 0 || !bus_rd) return "R6";
    if (a < 256) return "R3";
    if (a < 512) return "R4";
    if (a == 512) return "R2";
    if (a == 576) return "R7";
    return "R6";
  endfunction

  function automatic logic [3:0] exp_irq();
    logic [3:0] r;
    for (int c = 0; c < 4; c++)
      r[c] = ((m_raw & m_mask[c]) != 0) || (m_ipi[c] != 0) || m_rtc[c];
    return r;
  endfunction

  task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s at %0t: actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  function automatic void model_step();
    if (clr_vld) m_raw[clr_num] = 1'b0;
    if (set_vld) m_raw[set_num] = 1'b1;
    if (bus_wr) begin
      int a = int'(bus_addr);
      if ((a % 64) == 0 && a < 256) m_mask[a / 64] = bus_wdata;
      if (a == 576) begin
        for (int c = 0; c < 4; c++) begin
          int v = m_ipi[c] + int'(bus_wdata[12 + c]) - int'(bus_wdata[8 + c]);
          m_ipi[c] = (v > 15) ? 15 : ((v < 0) ? 0 : v);
          if (bus_wdata[4 + c]) m_rtc[c] = 0;
        end
      end
    end
    if (rtc_tick) for (int c = 0; c < 4; c++) m_rtc[c] = 1;
  endfunction

  // One compared clock: outputs checked before the edge, model advanced at it
  task automatic tick();
    #1;
    check("R10", 64'(irq_out), 64'(exp_irq()));
    check(tag_of(), bus_rdata, exp_rdata());
    @(posedge clk);
    model_step();
    @(negedge clk);
  endtask

  task automatic idle();
    bus_wr = 0; bus_rd = 0; set_vld = 0; clr_vld = 0; rtc_tick = 0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [63:0] d);
    idle(); bus_wr = 1; bus_addr = a; bus_wdata = d; tick(); idle();
  endtask

  task automatic rd(input logic [11:0] a, input logic [1:0] cpu);
    idle(); bus_rd = 1; bus_addr = a; bus_cpu = cpu; tick(); idle();
  endtask

  task automatic post(input logic [5:0] n);
    idle(); set_vld = 1; set_num = n; tick(); idle();
  endtask

  task automatic retire(input logic [5:0] n);
    idle(); clr_vld = 1; clr_num = n; tick(); idle();
  endtask

  initial begin
    model_clear();
    repeat (2) @(negedge clk);
    // R1: state during reset
    bus_rd = 1; bus_addr = 12'h200; #1;
    check("R1", bus_rdata, 64'd0);
    check("R1", 64'(irq_out), 64'd0);
    bus_rd = 0;
    @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1: everything reads zero after reset
    for (int c = 0; c < 4; c++) begin
      rd(12'(c * 64), 2'd0);
      check("R1", bus_rdata, 64'd0);
    end
    rd(12'h200, 2'd0);

    // R2: post and retire lines
    post(6'd0); post(6'd5); post(6'd63);
    rd(12'h200, 2'd1);
    retire(6'd5);
    rd(12'h200, 2'd1);
    // R2: set and clear of the same line in one cycle -> set wins
    set_vld = 1; set_num = 6'd9; clr_vld = 1; clr_num = 6'd9; tick(); idle();
    rd(12'h200, 2'd0);

    // R3 / R4 / R10: masks, pending views and outputs
    wr(12'h000, 64'h0000_0000_0000_0001);
    wr(12'h040, 64'h8000_0000_0000_0000);
    wr(12'h080, 64'h0000_0000_0000_0020);
    wr(12'h0C0, 64'hFFFF_FFFF_FFFF_FFFF);
    for (int c = 0; c < 4; c++) begin
      rd(12'(c * 64), 2'(c));
      rd(12'(256 + c * 64), 2'(c));
    end
    retire(6'd63);
    rd(12'h140, 2'd1);

    // R5: writes to pending and raw registers are ignored
    wr(12'h100, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h200, 64'h0);
    rd(12'h100, 2'd0);
    rd(12'h200, 2'd0);
    rd(12'h000, 2'd0);

    // R6: unmapped offsets read zero and writes there do nothing
    wr(12'h008, 64'hDEAD_BEEF_0000_0000);
    wr(12'h300, 64'hFFFF_FFFF_FFFF_FFFF);
    wr(12'h280, 64'h0000_0000_0000_F000);
    rd(12'h008, 2'd0); rd(12'h300, 2'd0); rd(12'hFC0, 2'd0); rd(12'h244, 2'd0);
    rd(12'h000, 2'd0);

    // R7: control register returns the caller's number
    for (int c = 0; c < 4; c++) rd(12'h240, 2'(c));

    // clear masks so that only RTC and IPI drive the outputs
    for (int c = 0; c < 4; c++) wr(12'(c * 64), 64'd0);

    // R8: tick, per-CPU clear, tick beating a clear
    idle(); rtc_tick = 1; tick(); idle();
    tick();
    wr(12'h240, 64'h0000_0000_0000_0010);
    wr(12'h240, 64'h0000_0000_0000_00E0);
    tick();
    idle(); rtc_tick = 1; bus_wr = 1; bus_addr = 12'h240; bus_wdata = 64'h40; tick(); idle();
    tick();
    wr(12'h240, 64'h0000_0000_0000_00F0);
    tick();

    // R9: saturate CPU 2 high, drain below zero, both bits together
    for (int k = 0; k < 17; k++) wr(12'h240, 64'h0000_0000_0000_4000);
    wr(12'h240, 64'h0000_0000_0000_4400);
    for (int k = 0; k < 17; k++) wr(12'h240, 64'h0000_0000_0000_0400);
    tick();
    wr(12'h240, 64'h0000_0000_0000_0100);
    tick();
    wr(12'h240, 64'h0000_0000_0000_1000);
    wr(12'h240, 64'h0000_0000_0000_1100);
    wr(12'h240, 64'h0000_0000_0000_0100);
    tick();

    // Mixed random traffic
    for (int k = 0; k < 600; k++) begin
      logic [11:0] pick [10];
      pick = '{12'h000, 12'h040, 12'h080, 12'h0C0, 12'h100, 12'h1C0,
               12'h200, 12'h240, 12'h208, 12'h3C0};
      set_vld  = ($urandom % 3) == 0;  set_num = 6'($urandom);
      clr_vld  = ($urandom % 3) == 0;  clr_num = 6'($urandom);
      rtc_tick = ($urandom % 20) == 0;
      bus_addr = pick[$urandom % 10];
      bus_cpu  = 2'($urandom);
      bus_rd   = ($urandom % 2) == 0;
      bus_wr   = ($urandom % 4) == 0;
      bus_wdata = {$urandom, $urandom};
      tick();
    end
    idle();
    repeat (4) tick();

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule